// File: doc/BRIEF.md
# MDIO Management Master

This block lets software read and write the registers of Ethernet PHYs over a two-wire management link. It produces the management clock (MDC) from the system clock through a programmable divider. It drives the bidirectional data line (MDIO) through an output value and a separate enable, and it samples the line for reads. Software programs a small register set over a plain write-strobe bus with combinational readback.

For a write, software loads the target PHY and register number and then writes the 16-bit value. That write launches the frame. For a read, software clears a command bit and then sets it again. The rising edge of that bit launches the frame. Software polls an indicator register: a busy flag covers the whole frame, and a not-valid flag covers a read until its data has been captured.

Every frame is 64 bit times long and is sent MSB first. It carries 32 preamble ones, the start code 01, an opcode (01 write, 10 read), five PHY address bits and five register bits. Then come a two-bit turnaround (10 on writes, released on reads) and sixteen data bits. A bit in the configuration register aborts any frame and returns the sequencer to idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Offset 2 holds the target: the PHY address in bits 12:8 and the register number in bits 4:0. It reads back with all other bits zero and is writable at any time.
- R2: A write to offset 3 while idle starts a write frame carrying bits 15:0 of the written word. The frame is 32 ones, 01, 01, PHY address, register number, 10, then the data, each bit presented MSB first and held across an MDC rising edge with the enable set.
- R3: A read frame starts only when bit 0 of offset 1 is written as 1 while it currently reads 0. Writing 1 over a stored 1 starts nothing.
- R4: A read frame sends 32 ones, 01, 10, PHY address and register number. It clears the output enable from the first turnaround bit to the end of the frame and samples MDIO at the MDC rising edges of the 16 data bits. It then returns the word in bits 15:0 of offset 4.
- R5: The busy flag, bit 0 of offset 5, is set from the clock after the starting write until the frame's final MDC falling edge. It lasts exactly 128×(D+1) clocks, where D is the effective divider.
- R6: The not-valid flag, bit 1 of offset 5, is set for the whole of a read frame and clears with busy once the read data are in offset 4. A write frame never sets it.
- R7: The divider is bits DIV_W-1:0 of offset 0 and reads back there. The effective divider D is the stored value, with 0 treated as 1. MDC has a period of 2×(D+1) clocks during a frame and rests low with the enable clear while idle.
- R8: The MDIO output and its enable change only while MDC is low, one clock after the MDC falling edge, and never while MDC is high.
- R9: While busy, writes to offsets 0 (without bit 31), 1 and 3 are ignored. They start no frame, do not alter the running frame, and leave the divider and command bit unchanged.
- R10: Writing offset 0 with bit 31 set aborts any frame at once. On the next clock busy, not-valid, command bit, MDC and enable are all clear, and the stored divider is unchanged. A later write without bit 31 sets the divider.
- R11: After reset busy and not-valid are clear, MDC and the enable are low, and the divider reads back as DEF_DIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register offset for write and readback |
| regWe | input | 1 | Register write strobe, one clock per write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational readback of the register at regAddr |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | Value driven on MDIO when the enable is set |
| mdioOe | output | 1 | MDIO output enable (tri-state control) |
| mdioIn | input | 1 | Sampled level of the MDIO line |

## Verification
The assertions assume that regWe, regAddr and regWdata are known at every clock edge and that a write lasts one clock. The read-start property assumes that not-valid can only rise after a command write. The stimulus meets this because every register access goes through a single task that holds the strobe for exactly one clock, set at a falling clock edge. The PHY model drives mdioIn only after an MDC falling edge and only over the turnaround and data bits of a read. This keeps the bus free of contention while the design owns the line.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  // Frame field widths
  localparam int PRE_BITS   = 32;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_IDX     = PRE_BITS + 4 + PHY_W + REG_W;
  localparam int DATA_IDX   = TA_IDX + 2;

  // Frame codes
  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  // Register offsets
  localparam logic [2:0] OFS_CFG   = 3'd0;
  localparam logic [2:0] OFS_CMD   = 3'd1;
  localparam logic [2:0] OFS_ADDR  = 3'd2;
  localparam logic [2:0] OFS_WDATA = 3'd3;
  localparam logic [2:0] OFS_RSTAT = 3'd4;
  localparam logic [2:0] OFS_IND   = 3'd5;
  localparam int CFG_RST_BIT = 31;

  // Control to datapath strobes
  typedef struct packed {
    logic loadWr;
    logic loadRd;
    logic shift;
    logic sample;
    logic capture;
  } seqStrobe_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regAddr,
  input  logic             regWe,
  input  logic             cfgRstIn,
  input  logic [DIV_W-1:0] divIn,
  input  logic             cmdIn,
  output logic [DIV_W-1:0] divReg,
  output logic             cmdBit,
  output logic             busy,
  output logic             notValid,
  output logic             mdc,
  output logic             mdioOe,
  output seqStrobe_t       strb
);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS);
  localparam logic [BIT_W-1:0] TA_POS   = BIT_W'(TA_IDX);
  localparam logic [BIT_W-1:0] DATA_POS = BIT_W'(DATA_IDX);

  logic [DIV_W-1:0] effDiv;
  logic [DIV_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             isRead;
  logic             cfgHit, softRst, cmdHit, wrStart, rdStart;
  logic             halfEnd, riseEv, fallEv, frameDone, shiftNow;

  always_comb begin
    effDiv    = (divReg == '0) ? DIV_W'(1) : divReg;
    cfgHit    = regWe && (regAddr == OFS_CFG);
    softRst   = cfgHit && cfgRstIn;
    cmdHit    = regWe && (regAddr == OFS_CMD);
    wrStart   = regWe && (regAddr == OFS_WDATA) && !busy;
    rdStart   = cmdHit && cmdIn && !cmdBit && !busy;
    halfEnd   = busy && (halfCnt == effDiv);
    riseEv    = halfEnd && !mdc;
    fallEv    = halfEnd && mdc;
    frameDone = fallEv && (bitIdx == LAST_IDX);
    // one clock after the falling edge of MDC
    shiftNow  = busy && !mdc && (halfCnt == '0) && (bitIdx != '0);
  end

  always_comb begin
    strb.loadWr  = wrStart;
    strb.loadRd  = rdStart;
    strb.shift   = shiftNow && !softRst;
    strb.sample  = riseEv && isRead && (bitIdx >= DATA_POS) && !softRst;
    strb.capture = frameDone && isRead && !softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg   <= DIV_W'(DEF_DIV);
      cmdBit   <= 1'b0;
      busy     <= 1'b0;
      notValid <= 1'b0;
      mdc      <= 1'b0;
      mdioOe   <= 1'b0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
    end else if (softRst) begin
      cmdBit   <= 1'b0;
      busy     <= 1'b0;
      notValid <= 1'b0;
      mdc      <= 1'b0;
      mdioOe   <= 1'b0;
      halfCnt  <= '0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
    end else begin
      if (cfgHit && !busy) divReg <= divIn;
      if (cmdHit && !busy) cmdBit <= cmdIn;
      if (wrStart || rdStart) begin
        busy     <= 1'b1;
        isRead   <= rdStart;
        notValid <= rdStart;
        mdc      <= 1'b0;
        mdioOe   <= 1'b1;
        halfCnt  <= '0;
        bitIdx   <= '0;
      end else if (busy) begin
        if (halfEnd) begin
          halfCnt <= '0;
          mdc     <= !mdc;
          if (riseEv) bitIdx <= bitIdx + BIT_W'(1);
        end else begin
          halfCnt <= halfCnt + DIV_W'(1);
        end
        if (shiftNow && isRead && (bitIdx == TA_POS)) mdioOe <= 1'b0;
        if (frameDone) begin
          busy     <= 1'b0;
          notValid <= 1'b0;
          mdioOe   <= 1'b0;
          isRead   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              addrWe,
  input  logic [PHY_W-1:0]  phyIn,
  input  logic [REG_W-1:0]  regIn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdioIn,
  output logic [PHY_W-1:0]  phyAddr,
  output logic [REG_W-1:0]  regNum,
  output logic [DATA_W-1:0] rdData,
  output logic              mdioOut
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameImg;
  logic [DATA_W-1:0]     rdShift;

  always_comb begin
    if (strb.loadRd)
      frameImg = {{PRE_BITS{1'b1}}, SOF_CODE, OP_RD, phyAddr, regNum,
                  2'b11, {DATA_W{1'b1}}};
    else
      frameImg = {{PRE_BITS{1'b1}}, SOF_CODE, OP_WR, phyAddr, regNum,
                  TA_WR, wdata};
  end

  assign mdioOut = shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddr  <= '0;
      regNum   <= '0;
      shiftReg <= '1;
      rdShift  <= '0;
      rdData   <= '0;
    end else begin
      if (addrWe) begin
        phyAddr <= phyIn;
        regNum  <= regIn;
      end
      if (strb.loadWr || strb.loadRd)
        shiftReg <= frameImg;
      else if (strb.shift)
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b1};
      if (strb.loadRd)
        rdShift <= '0;
      else if (strb.sample)
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (strb.capture) rdData <= rdShift;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  seqStrobe_t        strb;
  logic [DIV_W-1:0]  divReg;
  logic              cmdBit, busy, notValid;
  logic [PHY_W-1:0]  phyAddr;
  logic [REG_W-1:0]  regNum;
  logic [DATA_W-1:0] rdData;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata;

  mdio_mgmt_ctrl #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .cfgRstIn (regWdata[CFG_RST_BIT]),
    .divIn    (regWdata[DIV_W-1:0]),
    .cmdIn    (regWdata[0]),
    .divReg   (divReg),
    .cmdBit   (cmdBit),
    .busy     (busy),
    .notValid (notValid),
    .mdc      (mdc),
    .mdioOe   (mdioOe),
    .strb     (strb)
  );

  mdio_mgmt_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addrWe  (regWe && (regAddr == OFS_ADDR)),
    .phyIn   (regWdata[8 +: PHY_W]),
    .regIn   (regWdata[0 +: REG_W]),
    .wdata   (regWdata[DATA_W-1:0]),
    .mdioIn  (mdioIn),
    .phyAddr (phyAddr),
    .regNum  (regNum),
    .rdData  (rdData),
    .mdioOut (mdioOut)
  );

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CFG:   regRdata = 32'(divReg);
      OFS_CMD:   regRdata = 32'(cmdBit);
      OFS_ADDR: begin
        regRdata[8 +: PHY_W] = phyAddr;
        regRdata[0 +: REG_W] = regNum;
      end
      OFS_RSTAT: regRdata = 32'(rdData);
      OFS_IND:   regRdata = {30'b0, notValid, busy};
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
  import mdio_mgmt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regAddr,
  input logic        regWe,
  input logic [31:0] regWdata,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic        notValid
);
  AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFS_WDATA && !busy) |=> (busy && !notValid)); // R2

  AST_RD_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(notValid) |-> $past(regWe && regAddr == OFS_CMD && regWdata[0])); // R3

  AST_NV_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    notValid |-> busy); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R7

  AST_MDIO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe))); // R8

  AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == OFS_CFG && regWdata[CFG_RST_BIT])
      |=> (!busy && !notValid && !mdc && !mdioOe)); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk i_chk (.*);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                         A_WDATA = 3'd3, A_RSTAT = 3'd4, A_IND = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int errors = 0;
  int checks = 0;
  int clkCount = 0;
  int riseCnt = 0;
  int lastRise = 0;
  int period = 0;
  int stableErr = 0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyData = '0;
  logic prevOut = 1'b1, prevOe = 1'b0;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin @(posedge clk); clkCount++; end

  // bus monitor: capture each bit at the MDC rising edge
  initial forever begin
    @(posedge mdc);
    capBits  = {capBits[62:0], mdioOut};
    capOe    = {capOe[62:0], mdioOe};
    period   = clkCount - lastRise;
    lastRise = clkCount;
    riseCnt++;
  end

  // PHY model: drive turnaround and data after an MDC falling edge
  initial forever begin
    @(negedge mdc);
    if (riseCnt == 46) mdioIn = 1'b1;
    else if (riseCnt == 47) mdioIn = 1'b0;
    else if (riseCnt >= 48 && riseCnt < 64) mdioIn = phyData[63 - riseCnt];
  end

  // MDIO must not move while MDC is high
  initial forever begin
    @(negedge clk);
    if (rstN && mdc && (mdioOut !== prevOut || mdioOe !== prevOe)) stableErr++;
    prevOut = mdioOut;
    prevOe  = mdioOe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle(output int n);
    logic [31:0] v;
    n = 0;
    rdReg(A_IND, v);
    while (v[0]) begin
      n++;
      @(negedge clk);
      rdReg(A_IND, v);
    end
  endtask

  function automatic logic [63:0] frameOf(input bit rd, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rdReg(A_IND, v);  chk(v == 0, "R11 indicator", v, 0);
    rdReg(A_CFG, v);  chk(v == 4, "R11 divider", v, 4);
    chk(mdc == 0 && mdioOe == 0, "R11 pins", {mdc, mdioOe}, 0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wrReg(A_ADDR, 32'hFFFF_FFFF);
    rdReg(A_ADDR, v); chk(v == 32'h1F1F, "R1 field mask", v, 32'h1F1F);
    wrReg(A_ADDR, 32'h0000_150A);
    rdReg(A_ADDR, v); chk(v == 32'h150A, "R1 fields", v, 32'h150A);
  endtask

  task automatic t_write();
    logic [31:0] v;
    int n;
    wrReg(A_CFG, 1);
    riseCnt = 0;
    wrReg(A_WDATA, 32'hDEAD_A5C3);
    rdReg(A_IND, v); chk(v == 1, "R5 R6 busy only on write", v, 1);
    waitIdle(n);
    chk(n == 256, "R5 write duration", n, 256);
    chk(riseCnt == 64, "R2 bit count", riseCnt, 64);
    chk(capBits == frameOf(0, 5'h15, 5'h0A, 16'hA5C3), "R2 write frame",
        capBits, frameOf(0, 5'h15, 5'h0A, 16'hA5C3));
    chk(capOe == '1, "R2 enable held", capOe, '1);
    chk(period == 4, "R7 period div1", period, 4);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int n;
    phyData = 16'h3C5A;
    wrReg(A_CMD, 0);
    riseCnt = 0;
    wrReg(A_CMD, 1);
    rdReg(A_IND, v); chk(v == 3, "R6 busy and not-valid", v, 3);
    waitIdle(n);
    chk(n == 256, "R5 read duration", n, 256);
    chk(capBits[63:18] == frameOf(1, 5'h15, 5'h0A, 0)[63:18], "R4 read header",
        capBits[63:18], frameOf(1, 5'h15, 5'h0A, 0)[63:18]);
    chk(capOe == {{46{1'b1}}, 18'b0}, "R4 release", capOe, {{46{1'b1}}, 18'b0});
    rdReg(A_RSTAT, v); chk(v == 32'h3C5A, "R4 read data", v, 32'h3C5A);
    rdReg(A_IND, v); chk(v == 0, "R6 clear after read", v, 0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    int n;
    wrReg(A_CMD, 1);
    rdReg(A_IND, v); chk(v == 0, "R3 level ignored", v, 0);
    phyData = 16'h8001;
    wrReg(A_CMD, 0);
    riseCnt = 0;
    wrReg(A_CMD, 1);
    rdReg(A_IND, v); chk(v == 3, "R3 edge starts read", v, 3);
    waitIdle(n);
    rdReg(A_RSTAT, v); chk(v == 32'h8001, "R3 R4 second read", v, 32'h8001);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    int n;
    riseCnt = 0;
    wrReg(A_WDATA, 32'h1234);
    wrReg(A_CMD, 0);
    wrReg(A_WDATA, 32'hFFFF);
    wrReg(A_CFG, 3);
    waitIdle(n);
    chk(capBits == frameOf(0, 5'h15, 5'h0A, 16'h1234), "R9 frame untouched",
        capBits, frameOf(0, 5'h15, 5'h0A, 16'h1234));
    rdReg(A_CMD, v); chk(v == 1, "R9 command kept", v, 1);
    rdReg(A_CFG, v); chk(v == 1, "R9 divider kept", v, 1);
    repeat (20) @(negedge clk);
    rdReg(A_IND, v); chk(v == 0, "R9 no queued frame", v, 0);
  endtask

  task automatic t_div();
    logic [31:0] v;
    int n;
    wrReg(A_CFG, 3);
    rdReg(A_CFG, v); chk(v == 3, "R7 divider readback", v, 3);
    wrReg(A_WDATA, 32'h00FF);
    waitIdle(n);
    chk(n == 512, "R5 R7 duration div3", n, 512);
    chk(period == 8, "R7 period div3", period, 8);
    wrReg(A_CFG, 0);
    rdReg(A_CFG, v); chk(v == 0, "R7 zero readback", v, 0);
    wrReg(A_WDATA, 32'h0001);
    waitIdle(n);
    chk(period == 4, "R7 zero acts as one", period, 4);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    int n;
    wrReg(A_CFG, 1);
    wrReg(A_CMD, 0);
    wrReg(A_CMD, 1);
    repeat (101) @(negedge clk);
    wrReg(A_CFG, 32'h8000_0000);
    rdReg(A_IND, v); chk(v == 0, "R10 flags cleared", v, 0);
    chk(mdc == 0 && mdioOe == 0, "R10 pins idle", {mdc, mdioOe}, 0);
    rdReg(A_CFG, v); chk(v == 1, "R10 divider kept", v, 1);
    rdReg(A_CMD, v); chk(v == 0, "R10 command cleared", v, 0);
    wrReg(A_CFG, 2);
    rdReg(A_CFG, v); chk(v == 2, "R10 divider set", v, 2);
    riseCnt = 0;
    wrReg(A_WDATA, 32'h0F0F);
    waitIdle(n);
    chk(n == 384, "R10 R5 frame after reset", n, 384);
    chk(period == 6, "R7 period div2", period, 6);
    chk(capBits == frameOf(0, 5'h15, 5'h0A, 16'h0F0F), "R10 R2 frame after reset",
        capBits, frameOf(0, 5'h15, 5'h0A, 16'h0F0F));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_write();
    t_read();
    t_edge();
    t_busy();
    t_div();
    t_soft();
    chk(stableErr == 0, "R8 MDIO stable while MDC high", stableErr, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule